// File: doc/BRIEF.md
# Privileged Instruction Legality Checker

This block decides, for a hart that implements the hypervisor extension, whether each class of privileged or status-gated instruction may execute in the current privilege state. It takes the current privilege level and virtualisation bit, plus the relevant trap-control and configuration fields. For every instruction class it produces a registered illegal-instruction flag. Where the class can also be intercepted on behalf of a hypervisor, it produces a registered virtual-instruction flag as well.

The decode stage reads these flags to choose the exception for an instruction it has just recognised. A separate registered flag tells the memory side to carry out a cache-block invalidate as a flush. All outputs come from one register stage, so they follow their inputs by exactly one clock.

Top module: `priv_legal_chk`

## Requirements
- R1: The privilege state is `priv_lvl_i` (2'b00 user, 2'b01 supervisor, 2'b11 machine) together with `virt_i`. User with `virt_i`=0 is HU, user with `virt_i`=1 is VU, supervisor with `virt_i`=0 is HS and supervisor with `virt_i`=1 is VS. Level 2'b10 and machine level are both treated as M, whatever `virt_i` is. In M, every bit of `virt_o`, `inv_flush_o` and `ill_o[4:0]`, `ill_o[7]`, `ill_o[11:9]` is 0.
- R2: `ill_o[0]` (address-translation fence / invalidate) and `ill_o[2]` (guest-physical fence / invalidate) are set in HS when `tvm_i`=1, and in HU.
- R3: `ill_o[1]` (write/IR ordering fences) and `ill_o[3]` (guest-virtual fence / invalidate) are set only in HU. `ill_o[4]` (hypervisor load/store) is set in HU when `hu_en_i`=0.
- R4: `ill_o[5]` is set when `fs_i`=2'b00, and `ill_o[6]` when `vecs_i`=2'b00, in any mode. `ill_o[8]` is set when `frm_i` is greater than 4.
- R5: `ill_o[7]` (wait-for-interrupt) is set in HU, and in any non-M mode when `tw_i`=1. `virt_o[4]` is set in VU when `tw_i`=0, and in VS when `tw_i`=0 and `vtw_i`=1.
- R6: `virt_o[0]` is set in VS when `vtvm_i`=1, and in VU. `virt_o[1]` is set in VU. `virt_o[2]` (any hypervisor fence / invalidate) and `virt_o[3]` (hypervisor load/store) are set in VS and VU.
- R7: Each environment-configuration input is 4 bits {zero-enable[3], clean/flush-enable[2], invalidate-field[1:0]}. The invalidate field reads 2'b00 Off, 2'b01 Flush, 2'b11 Invalidate, and 2'b10 counts as Off. `ill_o[9]` (block zero) is set in any non-M mode when the machine zero-enable is 0, and in HU when the supervisor zero-enable is 0. `ill_o[10]` (clean/flush) follows the same pattern with the clean/flush-enable bits. `ill_o[11]` (invalidate) follows it with "invalidate field is Off".
- R8: `virt_o[5]` is set only when the machine zero-enable is 1, and then in VS when the hypervisor zero-enable is 0, or in VU when the hypervisor or supervisor zero-enable is 0. `virt_o[6]` follows the same pattern with the clean/flush-enable bits. `virt_o[7]` requires the machine invalidate field to be non-Off, and then follows the pattern with "field is Off".
- R9: `inv_flush_o` is set in HS when the machine field is Flush. It is set in HU when the machine or supervisor field is Flush, in VS when the machine or hypervisor field is Flush, and in VU when any of the three is Flush.
- R10: Every output reflects the inputs sampled at the previous rising clock edge. A synchronous active-high `rst` clears all outputs to 0.
- R11: For classes checked both ways (pairs ill/virt 0/0, 7/4, 9/5, 10/6, 11/7), the illegal and virtual flags are never both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| priv_lvl_i | input | 2 | Privilege level |
| virt_i | input | 1 | Virtualisation bit |
| tvm_i | input | 1 | Machine trap-virtual-memory bit |
| tw_i | input | 1 | Machine timeout-wait bit |
| vtvm_i | input | 1 | Hypervisor virtual trap-virtual-memory bit |
| vtw_i | input | 1 | Hypervisor virtual timeout-wait bit |
| hu_en_i | input | 1 | Hypervisor user-access enable for hypervisor load/store |
| fs_i | input | 2 | Floating-point status field |
| vecs_i | input | 2 | Vector status field |
| frm_i | input | 3 | Dynamic rounding-mode field |
| menv_i | input | 4 | Machine environment-configuration cache-block bits |
| henv_i | input | 4 | Hypervisor environment-configuration cache-block bits |
| senv_i | input | 4 | Supervisor environment-configuration cache-block bits |
| ill_o | output | 12 | Illegal-instruction flags, one per class |
| virt_o | output | 8 | Virtual-instruction flags, one per class |
| inv_flush_o | output | 1 | Perform cache-block invalidate as flush |

## Verification
The assertions compare registered outputs with `$past` of the input ports. They therefore assume that every input holds a defined value at each rising edge from the first cycle on, including during reset. The bench meets this by driving all inputs to known values at time zero. After that it changes them only on falling edges, so each set is held across the edge that captures it.

Both the assertions and the bench assume `fs_i`, `vecs_i` and `frm_i` are static status values, and they check them independently of mode. The bench vectors also cover the reserved level 2'b10 and the reserved invalidate code 2'b10, which the requirements define.

// File: rtl/priv_legal_pkg.sv
package priv_legal_pkg;

    localparam logic [1:0] LVL_USER  = 2'b00;
    localparam logic [1:0] LVL_SUPER = 2'b01;

    // invalidate-field codes; 2'b10 is reserved and read as Off
    localparam logic [1:0] INV_OFF   = 2'b00;
    localparam logic [1:0] INV_FLUSH = 2'b01;

    localparam int ILL_W  = 12;
    localparam int VIRT_W = 8;

    // illegal flag positions
    localparam int IL_ATFENCE = 0;
    localparam int IL_ORDFEN  = 1;
    localparam int IL_GPFENCE = 2;
    localparam int IL_GVFENCE = 3;
    localparam int IL_HLDST   = 4;
    localparam int IL_FPOFF   = 5;
    localparam int IL_VECOFF  = 6;
    localparam int IL_WAIT    = 7;
    localparam int IL_RMRSV   = 8;
    localparam int IL_CBZERO  = 9;
    localparam int IL_CBCLEAN = 10;
    localparam int IL_CBINV   = 11;

    // virtual flag positions
    localparam int VI_ATFENCE = 0;
    localparam int VI_ORDFEN  = 1;
    localparam int VI_HFENCE  = 2;
    localparam int VI_HLDST   = 3;
    localparam int VI_WAIT    = 4;
    localparam int VI_CBZERO  = 5;
    localparam int VI_CBCLEAN = 6;
    localparam int VI_CBINV   = 7;

    typedef struct packed {
        logic m;
        logic hs;
        logic hu;
        logic vs;
        logic vu;
    } mode_t;

    typedef struct packed {
        logic       zero_en;
        logic       clean_en;
        logic [1:0] inv_fld;
    } envcfg_t;

    function automatic logic inv_is_off(input logic [1:0] fld);
        return (fld == INV_OFF) || (fld == 2'b10);
    endfunction

    function automatic logic inv_is_flush(input logic [1:0] fld);
        return fld == INV_FLUSH;
    endfunction

endpackage

// File: rtl/priv_mode_decode.sv
module priv_mode_decode
    import priv_legal_pkg::*;
(
    input  logic [1:0] lvl_i,
    input  logic       virt_i,
    output mode_t      mode_o
);
    always_comb begin
        mode_o = '0;
        unique case (lvl_i)
            LVL_USER: begin
                mode_o.hu = !virt_i;
                mode_o.vu = virt_i;
            end
            LVL_SUPER: begin
                mode_o.hs = !virt_i;
                mode_o.vs = virt_i;
            end
            default: mode_o.m = 1'b1;
        endcase
    end
endmodule

// File: rtl/priv_illegal_eval.sv
module priv_illegal_eval
    import priv_legal_pkg::*;
#(
    parameter int          FRM_W   = 3,
    parameter int unsigned FRM_MAX = 4
) (
    input  logic              in_m_i,
    input  logic              in_hs_i,
    input  logic              in_hu_i,
    input  logic              tvm_i,
    input  logic              tw_i,
    input  logic              hu_en_i,
    input  logic [1:0]        fs_i,
    input  logic [1:0]        vecs_i,
    input  logic [FRM_W-1:0]  frm_i,
    input  envcfg_t           menv_i,
    input  envcfg_t           senv_i,
    output logic [ILL_W-1:0]  ill_o
);
    logic not_m;
    logic tlb_fence_bad;

    always_comb begin
        not_m         = !in_m_i;
        tlb_fence_bad = (in_hs_i && tvm_i) || in_hu_i;
        ill_o             = '0;
        ill_o[IL_ATFENCE] = tlb_fence_bad;
        ill_o[IL_GPFENCE] = tlb_fence_bad;
        ill_o[IL_ORDFEN]  = in_hu_i;
        ill_o[IL_GVFENCE] = in_hu_i;
        ill_o[IL_HLDST]   = in_hu_i && !hu_en_i;
        ill_o[IL_FPOFF]   = (fs_i == 2'b00);
        ill_o[IL_VECOFF]  = (vecs_i == 2'b00);
        ill_o[IL_WAIT]    = in_hu_i || (not_m && tw_i);
        ill_o[IL_RMRSV]   = (frm_i > FRM_W'(FRM_MAX));
        ill_o[IL_CBZERO]  = (not_m && !menv_i.zero_en) || (in_hu_i && !senv_i.zero_en);
        ill_o[IL_CBCLEAN] = (not_m && !menv_i.clean_en) || (in_hu_i && !senv_i.clean_en);
        ill_o[IL_CBINV]   = (not_m && inv_is_off(menv_i.inv_fld))
                         || (in_hu_i && inv_is_off(senv_i.inv_fld));
    end
endmodule

// File: rtl/priv_virtual_eval.sv
module priv_virtual_eval
    import priv_legal_pkg::*;
(
    input  logic              in_vs_i,
    input  logic              in_vu_i,
    input  logic              tw_i,
    input  logic              vtvm_i,
    input  logic              vtw_i,
    input  envcfg_t           menv_i,
    input  envcfg_t           henv_i,
    input  envcfg_t           senv_i,
    output logic [VIRT_W-1:0] virt_o
);
    logic any_v;

    always_comb begin
        any_v  = in_vs_i || in_vu_i;
        virt_o = '0;
        virt_o[VI_ATFENCE] = (in_vs_i && vtvm_i) || in_vu_i;
        virt_o[VI_ORDFEN]  = in_vu_i;
        virt_o[VI_HFENCE]  = any_v;
        virt_o[VI_HLDST]   = any_v;
        virt_o[VI_WAIT]    = !tw_i && (in_vu_i || (in_vs_i && vtw_i));
        virt_o[VI_CBZERO]  = menv_i.zero_en &&
            ((in_vs_i && !henv_i.zero_en) ||
             (in_vu_i && (!henv_i.zero_en || !senv_i.zero_en)));
        virt_o[VI_CBCLEAN] = menv_i.clean_en &&
            ((in_vs_i && !henv_i.clean_en) ||
             (in_vu_i && (!henv_i.clean_en || !senv_i.clean_en)));
        virt_o[VI_CBINV]   = !inv_is_off(menv_i.inv_fld) &&
            ((in_vs_i && inv_is_off(henv_i.inv_fld)) ||
             (in_vu_i && (inv_is_off(henv_i.inv_fld) || inv_is_off(senv_i.inv_fld))));
    end
endmodule

// File: rtl/priv_flush_eval.sv
module priv_flush_eval
    import priv_legal_pkg::*;
(
    input  logic       in_hs_i,
    input  logic       in_hu_i,
    input  logic       in_vs_i,
    input  logic       in_vu_i,
    input  logic [1:0] m_fld_i,
    input  logic [1:0] h_fld_i,
    input  logic [1:0] s_fld_i,
    output logic       flush_o
);
    logic mf, hf, sf;

    always_comb begin
        mf = inv_is_flush(m_fld_i);
        hf = inv_is_flush(h_fld_i);
        sf = inv_is_flush(s_fld_i);
        flush_o = (in_hs_i && mf)
               || (in_hu_i && (mf || sf))
               || (in_vs_i && (mf || hf))
               || (in_vu_i && (mf || hf || sf));
    end
endmodule

// File: rtl/priv_legal_chk.sv
module priv_legal_chk
    import priv_legal_pkg::*;
#(
    parameter int          FRM_W   = 3,
    parameter int unsigned FRM_MAX = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        priv_lvl_i,
    input  logic              virt_i,
    input  logic              tvm_i,
    input  logic              tw_i,
    input  logic              vtvm_i,
    input  logic              vtw_i,
    input  logic              hu_en_i,
    input  logic [1:0]        fs_i,
    input  logic [1:0]        vecs_i,
    input  logic [FRM_W-1:0]  frm_i,
    input  logic [3:0]        menv_i,
    input  logic [3:0]        henv_i,
    input  logic [3:0]        senv_i,
    output logic [ILL_W-1:0]  ill_o,
    output logic [VIRT_W-1:0] virt_o,
    output logic              inv_flush_o
);
    mode_t               mode;
    envcfg_t             menv, henv, senv;
    logic [ILL_W-1:0]    ill_d;
    logic [VIRT_W-1:0]   virt_d;
    logic                flush_d;

    assign menv = envcfg_t'(menv_i);
    assign henv = envcfg_t'(henv_i);
    assign senv = envcfg_t'(senv_i);

    priv_mode_decode u_mode (
        .lvl_i  (priv_lvl_i),
        .virt_i (virt_i),
        .mode_o (mode)
    );

    priv_illegal_eval #(.FRM_W(FRM_W), .FRM_MAX(FRM_MAX)) u_ill (
        .in_m_i  (mode.m),
        .in_hs_i (mode.hs),
        .in_hu_i (mode.hu),
        .tvm_i   (tvm_i),
        .tw_i    (tw_i),
        .hu_en_i (hu_en_i),
        .fs_i    (fs_i),
        .vecs_i  (vecs_i),
        .frm_i   (frm_i),
        .menv_i  (menv),
        .senv_i  (senv),
        .ill_o   (ill_d)
    );

    priv_virtual_eval u_virt (
        .in_vs_i (mode.vs),
        .in_vu_i (mode.vu),
        .tw_i    (tw_i),
        .vtvm_i  (vtvm_i),
        .vtw_i   (vtw_i),
        .menv_i  (menv),
        .henv_i  (henv),
        .senv_i  (senv),
        .virt_o  (virt_d)
    );

    priv_flush_eval u_flush (
        .in_hs_i (mode.hs),
        .in_hu_i (mode.hu),
        .in_vs_i (mode.vs),
        .in_vu_i (mode.vu),
        .m_fld_i (menv.inv_fld),
        .h_fld_i (henv.inv_fld),
        .s_fld_i (senv.inv_fld),
        .flush_o (flush_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ill_o       <= '0;
            virt_o      <= '0;
            inv_flush_o <= 1'b0;
        end else begin
            ill_o       <= ill_d;
            virt_o      <= virt_d;
            inv_flush_o <= flush_d;
        end
    end

    // R1: machine level (or reserved level) never traps a privileged class
    assert_m_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        ($past(priv_lvl_i) != LVL_USER && $past(priv_lvl_i) != LVL_SUPER)
        |-> (virt_o == '0 && !inv_flush_o && ill_o[4:0] == '0
             && !ill_o[7] && ill_o[11:9] == '0));

    // R6: without virtualisation no virtual-instruction flag appears
    assert_nonvirt_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        !$past(virt_i) |-> virt_o == '0);

    // R4: rounding-mode flag follows the sampled field value
    assert_frm_rsvd_R4: assert property (@(posedge clk) disable iff (rst)
        ($past(frm_i) <= FRM_W'(FRM_MAX)) |-> !ill_o[IL_RMRSV]);

    // R10: output follows the previous-cycle reset
    assert_reset_clear_R10: assert property (@(posedge clk)
        $past(rst) |-> (ill_o == '0 && virt_o == '0 && !inv_flush_o));

    // R11: no class flagged both ways
    assert_exclusive_R11: assert property (@(posedge clk) disable iff (rst)
        !((ill_o[IL_ATFENCE] && virt_o[VI_ATFENCE]) ||
          (ill_o[IL_WAIT]    && virt_o[VI_WAIT])    ||
          (ill_o[IL_CBZERO]  && virt_o[VI_CBZERO])  ||
          (ill_o[IL_CBCLEAN] && virt_o[VI_CBCLEAN]) ||
          (ill_o[IL_CBINV]   && virt_o[VI_CBINV])));

    // R9: no flush conversion while every invalidate field was non-Flush
    assert_flush_needs_flush_R9: assert property (@(posedge clk) disable iff (rst)
        ($past(menv_i[1:0]) != INV_FLUSH && $past(henv_i[1:0]) != INV_FLUSH
         && $past(senv_i[1:0]) != INV_FLUSH) |-> !inv_flush_o);

endmodule

// File: tb/priv_legal_chk_bench.sv
module priv_legal_chk_bench;

    typedef struct packed {
        logic [1:0]  lvl;
        logic        v;
        logic        tvm;
        logic        tw;
        logic        vtvm;
        logic        vtw;
        logic        hu;
        logic [1:0]  fs;
        logic [1:0]  vs;
        logic [2:0]  frm;
        logic [3:0]  me;
        logic [3:0]  he;
        logic [3:0]  se;
        logic [11:0] ill;
        logic [7:0]  virt;
        logic        fl;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 27;
    // fields: lvl v tvm tw vtvm vtw hu fs vs frm menv henv senv | ill virt flush | req
    localparam vec_t TBL [NV] = '{
        '{2'b11,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b01,2'b01,3'd0,4'hF,4'hF,4'hF,12'h000,8'h00,1'b0,4'd1}, // R1 M
        '{2'b01,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b01,2'b01,3'd0,4'hF,4'hF,4'hF,12'h000,8'h00,1'b0,4'd2}, // R2 HS clean
        '{2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b01,2'b01,3'd0,4'hF,4'hF,4'hF,12'h09F,8'h00,1'b0,4'd3}, // R3 HU
        '{2'b01,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,2'b01,2'b01,3'd0,4'hF,4'hF,4'hF,12'h000,8'h0C,1'b0,4'd6}, // R6 VS
        '{2'b00,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,2'b01,2'b01,3'd0,4'hF,4'hF,4'hF,12'h000,8'h1F,1'b0,4'd6}, // R6 VU
        '{2'b01,1'b0,1'b1,1'b1,1'b0,1'b0,1'b0,2'b01,2'b01,3'd0,4'hF,4'hF,4'hF,12'h085,8'h00,1'b0,4'd2}, // R2 HS tvm tw
        '{2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b1,2'b01,2'b01,3'd0,4'hF,4'hF,4'hF,12'h08F,8'h00,1'b0,4'd3}, // R3 HU hu_en
        '{2'b01,1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,2'b01,2'b01,3'd0,4'hF,4'hF,4'hF,12'h000,8'h1D,1'b0,4'd5}, // R5 VS vtvm vtw
        '{2'b01,1'b1,1'b0,1'b1,1'b0,1'b1,1'b0,2'b01,2'b01,3'd0,4'hF,4'hF,4'hF,12'h080,8'h0C,1'b0,4'd5}, // R5 VS tw
        '{2'b00,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,2'b01,2'b01,3'd0,4'hF,4'hF,4'hF,12'h080,8'h0F,1'b0,4'd5}, // R5 VU tw
        '{2'b11,1'b0,1'b0,1'b1,1'b0,1'b0,1'b0,2'b00,2'b00,3'd5,4'hF,4'hF,4'hF,12'h160,8'h00,1'b0,4'd4}, // R4 M off rsvd
        '{2'b01,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b01,2'b00,3'd4,4'hF,4'hF,4'hF,12'h040,8'h00,1'b0,4'd4}, // R4 frm=4 ok
        '{2'b01,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b01,2'b01,3'd0,4'h0,4'hF,4'hF,12'hE00,8'h00,1'b0,4'd7}, // R7 HS menv off
        '{2'b11,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b01,2'b01,3'd0,4'h0,4'h0,4'h0,12'h000,8'h00,1'b0,4'd7}, // R7 M exempt
        '{2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b01,2'b01,3'd0,4'hF,4'hF,4'h0,12'hE9F,8'h00,1'b0,4'd7}, // R7 HU senv off
        '{2'b01,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,2'b01,2'b01,3'd0,4'hF,4'h0,4'hF,12'h000,8'hEC,1'b0,4'd8}, // R8 VS henv off
        '{2'b00,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,2'b01,2'b01,3'd0,4'hF,4'hF,4'h0,12'h000,8'hFF,1'b0,4'd8}, // R8 VU senv off
        '{2'b00,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,2'b01,2'b01,3'd0,4'h0,4'hF,4'h0,12'hE00,8'h1F,1'b0,4'd8}, // R8 VU menv off
        '{2'b01,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b01,2'b01,3'd0,4'hD,4'hF,4'hF,12'h000,8'h00,1'b1,4'd9}, // R9 HS m flush
        '{2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b01,2'b01,3'd0,4'hF,4'hF,4'hD,12'h09F,8'h00,1'b1,4'd9}, // R9 HU s flush
        '{2'b01,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,2'b01,2'b01,3'd0,4'hF,4'hD,4'hF,12'h000,8'h0C,1'b1,4'd9}, // R9 VS h flush
        '{2'b00,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,2'b01,2'b01,3'd0,4'hF,4'hF,4'hD,12'h000,8'h1F,1'b1,4'd9}, // R9 VU s flush
        '{2'b01,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b01,2'b01,3'd0,4'hF,4'hF,4'hD,12'h000,8'h00,1'b0,4'd9}, // R9 HS ignores s
        '{2'b01,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,2'b01,2'b01,3'd0,4'hF,4'hF,4'hD,12'h000,8'h0C,1'b0,4'd9}, // R9 VS ignores s
        '{2'b00,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b01,2'b01,3'd0,4'hE,4'hF,4'hF,12'h89F,8'h00,1'b0,4'd7}, // R7 reserved code Off
        '{2'b11,1'b1,1'b0,1'b0,1'b0,1'b0,1'b0,2'b01,2'b01,3'd0,4'hF,4'hF,4'hF,12'h000,8'h00,1'b0,4'd1}, // R1 M with V
        '{2'b10,1'b0,1'b0,1'b0,1'b0,1'b0,1'b0,2'b01,2'b01,3'd0,4'hF,4'hF,4'hF,12'h000,8'h00,1'b0,4'd1}  // R1 level 2'b10
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  priv_lvl_i = 2'b11;
    logic        virt_i = 1'b0, tvm_i = 1'b0, tw_i = 1'b0, vtvm_i = 1'b0, vtw_i = 1'b0, hu_en_i = 1'b0;
    logic [1:0]  fs_i = 2'b01, vecs_i = 2'b01;
    logic [2:0]  frm_i = 3'd0;
    logic [3:0]  menv_i = 4'hF, henv_i = 4'hF, senv_i = 4'hF;
    logic [11:0] ill_o;
    logic [7:0]  virt_o;
    logic        inv_flush_o;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    priv_legal_chk u_priv_legal_chk (
        .clk(clk), .rst(rst), .priv_lvl_i(priv_lvl_i), .virt_i(virt_i),
        .tvm_i(tvm_i), .tw_i(tw_i), .vtvm_i(vtvm_i), .vtw_i(vtw_i),
        .hu_en_i(hu_en_i), .fs_i(fs_i), .vecs_i(vecs_i), .frm_i(frm_i),
        .menv_i(menv_i), .henv_i(henv_i), .senv_i(senv_i),
        .ill_o(ill_o), .virt_o(virt_o), .inv_flush_o(inv_flush_o)
    );

    task automatic drive(input vec_t t);
        priv_lvl_i = t.lvl; virt_i = t.v; tvm_i = t.tvm; tw_i = t.tw;
        vtvm_i = t.vtvm; vtw_i = t.vtw; hu_en_i = t.hu; fs_i = t.fs;
        vecs_i = t.vs; frm_i = t.frm; menv_i = t.me; henv_i = t.he; senv_i = t.se;
    endtask

    task automatic check(input string req, input logic [11:0] ei,
                         input logic [7:0] ev, input logic ef, input string what);
        n_chk++;
        if (ill_o !== ei || virt_o !== ev || inv_flush_o !== ef) begin
            n_fail++;
            $display("FAIL %s %s: got ill=%h virt=%h fl=%b expected ill=%h virt=%h fl=%b",
                     req, what, ill_o, virt_o, inv_flush_o, ei, ev, ef);
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10", 12'h000, 8'h00, 1'b0, "reset state");
        rst = 1'b0;
        for (int i = 0; i < NV; i++) begin
            drive(TBL[i]);
            @(posedge clk);
            @(negedge clk);
            check($sformatf("R%0d", TBL[i].req), TBL[i].ill, TBL[i].virt, TBL[i].fl,
                  $sformatf("vector %0d", i));
        end
        // R10: one-cycle latency: change inputs, output must still show old value before edge
        drive(TBL[2]);
        @(posedge clk);
        @(negedge clk);
        drive(TBL[4]);
        #1;
        check("R10", 12'h09F, 8'h00, 1'b0, "held before edge");
        @(posedge clk);
        @(negedge clk);
        check("R10", 12'h000, 8'h1F, 1'b0, "updated after edge");
        // R10: synchronous reset clears outputs while inputs demand flags
        drive(TBL[19]);
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R10", 12'h000, 8'h00, 1'b0, "mid-run reset");
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R9", 12'h09F, 8'h00, 1'b1, "after reset release");
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule